// File: doc/BRIEF.md
# Dual Sixteen-Bit Interval Timer With Write Latches

This block holds two 16-bit down-counters behind a small byte-wide register bus. Each counter has a 16-bit latch that software fills one byte at a time; writing the upper byte copies the whole latch into the counter and starts it. Counting advances only on cycles where the `tick` enable is high, so the same block serves any prescaled time base.

The first timer can run in one of two modes. In the single-shot mode it counts down once, raises its flag and then rests at zero. In the periodic mode it refills itself from the latch each time it runs out. It can also invert a square-wave output bit on every timeout; that bit is meant to take over one port output pin in the surrounding peripheral. The second timer has only the single-shot mode. Each timer owns one flag bit. A read of the timer's low counter byte clears that flag. The two mode bits come from an auxiliary control register that lives outside this block.

Register offsets (4-bit `addr`): 0x4 writes the first timer's low latch byte and reads its low counter byte. 0x5 writes the high latch byte and starts the counter, and reads the high counter byte. 0x6 reads or writes the low latch byte. 0x7 reads or writes the high latch byte and does not load the counter. 0x8 and 0x9 serve the second timer in the way 0x4 and 0x5 serve the first.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters read 0xFFFF, both latches read 0x0000, both flags and `wave_out` are 0, and the counters do not change on ticks until they are started.
- R2: A write to 0x4 or 0x6 stores the first timer's low latch byte and a write to 0x7 stores its high latch byte; none of these changes the counter; reads of 0x6 and 0x7 return the latch bytes.
- R3: A write of value H to 0x5 stores H as the high latch byte, loads the counter with {H, low latch byte}, clears the first flag and starts the timer; a tick in that same cycle does not decrement the counter.
- R4: In single-shot mode a counter started with value N decrements once per tick, sets its flag on tick N+1 and then stays at zero; it does not set its flag again until it is restarted through its high byte.
- R5: When `t1_autoreload` is 1, a tick that finds the first counter at 1 or 0 reloads it from the latch and sets the first flag. With a latch of 4, the counter reads 2 after six ticks.
- R6: When `t1_pin_toggle` is 1, each first-timer timeout inverts `wave_out`; when it is 0, `wave_out` holds its level.
- R7: A read of 0x4 clears the first flag and a read of 0x8 clears the second flag; reads of other offsets leave the flags unchanged.
- R8: If a timeout and a flag-clearing read fall in the same cycle, the flag ends up set.
- R9: The second timer uses 0x8 as its low latch and low counter byte and 0x9 as its high byte and start. It stays single-shot whatever `t1_autoreload` is.
- R10: `rdata` is combinational: with `rd_en` high it shows the byte selected by `addr`. It is 0x00 for offsets other than 0x4 to 0x9, and it is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable for both timers |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| t1_autoreload | input | 1 | First timer periodic mode |
| t1_pin_toggle | input | 1 | First timer timeouts invert `wave_out` |
| rdata | output | 8 | Read data |
| t1_flag | output | 1 | First timer timeout flag |
| t2_flag | output | 1 | Second timer timeout flag |
| wave_out | output | 1 | Square-wave level from first timer timeouts |

## Verification
A read of a timer's low counter byte can land in the very cycle in which that timer times out. The clear and the set then act on the same flag at one edge. The bench counts a single-shot counter down to zero and then reads 0x4 with `tick` still high. It expects the returned byte to be 0x00 and the flag to be high afterwards. A second read must then clear the flag. Restart writes that coincide with a tick are also provoked, and the counter must keep its freshly loaded value.

// File: rtl/dit_pkg.sv
package dit_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int N_TMR  = 2;

    localparam logic [ADDR_W-1:0] A_T1_CNT_LO = 4'h4;
    localparam logic [ADDR_W-1:0] A_T1_CNT_HI = 4'h5;
    localparam logic [ADDR_W-1:0] A_T1_LAT_LO = 4'h6;
    localparam logic [ADDR_W-1:0] A_T1_LAT_HI = 4'h7;
    localparam logic [ADDR_W-1:0] A_T2_CNT_LO = 4'h8;
    localparam logic [ADDR_W-1:0] A_T2_CNT_HI = 4'h9;

    // per-timer strobes produced by the decoder
    typedef struct packed {
        logic wr_lat_lo;
        logic wr_lat_hi;
        logic start;
        logic rd_cnt_lo;
        logic rd_cnt_hi;
        logic rd_lat_lo;
        logic rd_lat_hi;
    } tmr_ctl_t;
endpackage

// File: rtl/dit_decode.sv
module dit_decode
    import dit_pkg::*;
(
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    output tmr_ctl_t [N_TMR-1:0]           ctl_o,
    output logic     [N_TMR-1:0]           clr_o
);
    always_comb begin
        ctl_o = '0;
        // first timer: separate counter and latch offsets
        ctl_o[0].wr_lat_lo = wr_en && (addr == A_T1_CNT_LO || addr == A_T1_LAT_LO);
        ctl_o[0].wr_lat_hi = wr_en && (addr == A_T1_LAT_HI);
        ctl_o[0].start     = wr_en && (addr == A_T1_CNT_HI);
        ctl_o[0].rd_cnt_lo = rd_en && (addr == A_T1_CNT_LO);
        ctl_o[0].rd_cnt_hi = rd_en && (addr == A_T1_CNT_HI);
        ctl_o[0].rd_lat_lo = rd_en && (addr == A_T1_LAT_LO);
        ctl_o[0].rd_lat_hi = rd_en && (addr == A_T1_LAT_HI);
        // second timer: counter offsets only
        ctl_o[1].wr_lat_lo = wr_en && (addr == A_T2_CNT_LO);
        ctl_o[1].start     = wr_en && (addr == A_T2_CNT_HI);
        ctl_o[1].rd_cnt_lo = rd_en && (addr == A_T2_CNT_LO);
        ctl_o[1].rd_cnt_hi = rd_en && (addr == A_T2_CNT_HI);
        // flag clear on low counter byte reads
        clr_o[0] = ctl_o[0].rd_cnt_lo;
        clr_o[1] = ctl_o[1].rd_cnt_lo;
    end
endmodule

// File: rtl/dit_counter.sv
module dit_counter
    import dit_pkg::*;
#(
    parameter int BW         = 8,
    parameter bit CAN_RELOAD = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          free_run,
    input  tmr_ctl_t      ctl,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata_o,
    output logic          tmo_o
);
    localparam int CNT_W = 2 * BW;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lat;
        logic             armed;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    reload_en;

    assign reload_en = free_run && CAN_RELOAD;

    always_comb begin
        st_d  = st_q;
        tmo_o = 1'b0;
        if (ctl.wr_lat_lo) st_d.lat[BW-1:0] = wdata;
        if (ctl.wr_lat_hi || ctl.start) st_d.lat[CNT_W-1:BW] = wdata;
        if (ctl.start) begin
            // load wins over any tick in the same cycle
            st_d.cnt   = {wdata, st_q.lat[BW-1:0]};
            st_d.armed = 1'b1;
        end else if (tick && st_q.armed) begin
            if (reload_en) begin
                if (st_q.cnt <= CNT_W'(1)) begin
                    st_d.cnt = st_q.lat;
                    tmo_o    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end else if (st_q.cnt == '0) begin
                tmo_o      = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '1;
            st_q.lat   <= '0;
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = ({BW{ctl.rd_cnt_lo}} & st_q.cnt[BW-1:0])
                   | ({BW{ctl.rd_cnt_hi}} & st_q.cnt[CNT_W-1:BW])
                   | ({BW{ctl.rd_lat_lo}} & st_q.lat[BW-1:0])
                   | ({BW{ctl.rd_lat_hi}} & st_q.lat[CNT_W-1:BW]);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              t1_autoreload,
    input  logic              t1_pin_toggle,
    output logic [BYTE_W-1:0] rdata,
    output logic              t1_flag,
    output logic              t2_flag,
    output logic              wave_out
);
    typedef struct packed {
        logic [N_TMR-1:0] flag;
        logic             wave;
    } top_st_t;

    tmr_ctl_t [N_TMR-1:0]             ctl;
    logic     [N_TMR-1:0]             clr;
    logic     [N_TMR-1:0]             tmo;
    logic     [N_TMR-1:0][BYTE_W-1:0] rd_part;
    top_st_t                          st_d, st_q;

    dit_decode u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .ctl_o (ctl),
        .clr_o (clr)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        dit_counter #(
            .BW         (BYTE_W),
            .CAN_RELOAD (i == 0)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .free_run (t1_autoreload),
            .ctl      (ctl[i]),
            .wdata    (wdata),
            .rdata_o  (rd_part[i]),
            .tmo_o    (tmo[i])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_TMR; i++) begin
            // a timeout in the same cycle beats the clear
            st_d.flag[i] = (st_q.flag[i] & ~clr[i] & ~ctl[i].start) | tmo[i];
        end
        st_d.wave = st_q.wave ^ (tmo[0] & t1_pin_toggle);
        rdata = '0;
        for (int i = 0; i < N_TMR; i++) rdata = rdata | rd_part[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign t1_flag  = st_q.flag[0];
    assign t2_flag  = st_q.flag[1];
    assign wave_out = st_q.wave;
endmodule

// File: rtl/dit_checker.sv
module dit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic       rd_en,
    input logic [3:0] addr,
    input logic       t1_pin_toggle,
    input logic [7:0] rdata,
    input logic       t1_flag,
    input logic       t2_flag,
    input logic       wave_out
);
    // R4
    t1_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t1_flag) |-> $past(tick));
    // R9
    t2_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t2_flag) |-> $past(tick));
    // R7
    t1_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'h4 && !tick) |=> !t1_flag);
    // R7
    t2_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'h8 && !tick) |=> !t2_flag);
    // R3
    t1_start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h5) |=> !t1_flag);
    // R9
    t2_start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h9) |=> !t2_flag);
    // R6
    wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !t1_pin_toggle |=> $stable(wave_out));
    // R6
    wave_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wave_out) |-> t1_flag);
    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == 8'h00);
endmodule

bind dual_interval_timer dit_checker u_dit_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .t1_pin_toggle (t1_pin_toggle),
    .rdata         (rdata),
    .t1_flag       (t1_flag),
    .t2_flag       (t2_flag),
    .wave_out      (wave_out)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 52;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_FL = 2'd3;

    // {op[25:24], addr[23:20], data[19:12], expected[11:4], requirement[3:0]}
    // TK data: bit0 autoreload, bit1 pin toggle. FL expected: {wave, t2, t1}.
    localparam logic [25:0] VEC [N_VEC] = '{
        {OP_WR, 4'h4, 8'h03, 8'h00, 4'd2},   // R2
        {OP_WR, 4'h5, 8'h00, 8'h00, 4'd3},   // R3
        {OP_RD, 4'h6, 8'h00, 8'h03, 4'd2},   // R2
        {OP_RD, 4'h4, 8'h00, 8'h03, 4'd3},   // R3
        {OP_RD, 4'h5, 8'h00, 8'h00, 4'd3},   // R3
        {OP_TK, 4'h0, 8'h00, 8'h00, 4'd4},   // R4
        {OP_TK, 4'h0, 8'h00, 8'h00, 4'd4},
        {OP_TK, 4'h0, 8'h00, 8'h00, 4'd4},
        {OP_RD, 4'h4, 8'h00, 8'h00, 4'd4},   // R4 at zero
        {OP_FL, 4'h0, 8'h00, 8'h00, 4'd4},   // R4 not yet
        {OP_TK, 4'h0, 8'h00, 8'h00, 4'd4},
        {OP_FL, 4'h0, 8'h00, 8'h01, 4'd4},   // R4 tick N+1
        {OP_TK, 4'h0, 8'h00, 8'h00, 4'd4},
        {OP_RD, 4'h4, 8'h00, 8'h00, 4'd4},   // R4 stays zero
        {OP_FL, 4'h0, 8'h00, 8'h00, 4'd7},   // R7
        {OP_TK, 4'h0, 8'h00, 8'h00, 4'd4},
        {OP_TK, 4'h0, 8'h00, 8'h00, 4'd4},
        {OP_FL, 4'h0, 8'h00, 8'h00, 4'd4},   // R4 no refire
        {OP_WR, 4'h8, 8'h02, 8'h00, 4'd9},   // R9
        {OP_WR, 4'h9, 8'h00, 8'h00, 4'd9},
        {OP_RD, 4'h8, 8'h00, 8'h02, 4'd9},   // R9
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd9},
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd9},
        {OP_FL, 4'h0, 8'h00, 8'h00, 4'd9},   // R9
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd9},
        {OP_FL, 4'h0, 8'h00, 8'h02, 4'd9},   // R9 single-shot
        {OP_RD, 4'h9, 8'h00, 8'h00, 4'd7},   // R7
        {OP_FL, 4'h0, 8'h00, 8'h02, 4'd7},   // R7 kept
        {OP_RD, 4'h8, 8'h00, 8'h00, 4'd7},   // R7
        {OP_FL, 4'h0, 8'h00, 8'h00, 4'd7},   // R7 cleared
        {OP_WR, 4'h4, 8'h04, 8'h00, 4'd5},   // R5
        {OP_WR, 4'h5, 8'h00, 8'h00, 4'd5},
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd5},
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd5},
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd5},
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd5},
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd5},
        {OP_TK, 4'h0, 8'h01, 8'h00, 4'd5},
        {OP_FL, 4'h0, 8'h00, 8'h01, 4'd5},   // R5 flag, R6 wave held
        {OP_RD, 4'h4, 8'h00, 8'h02, 4'd5},   // R5 reads 2
        {OP_RD, 4'h5, 8'h00, 8'h00, 4'd5},
        {OP_FL, 4'h0, 8'h00, 8'h00, 4'd6},   // R6
        {OP_TK, 4'h0, 8'h03, 8'h00, 4'd6},
        {OP_TK, 4'h0, 8'h03, 8'h00, 4'd6},
        {OP_FL, 4'h0, 8'h00, 8'h05, 4'd6},   // R6 toggled high
        {OP_RD, 4'h4, 8'h00, 8'h04, 4'd5},   // R5 reloaded
        {OP_TK, 4'h0, 8'h03, 8'h00, 4'd6},
        {OP_TK, 4'h0, 8'h03, 8'h00, 4'd6},
        {OP_TK, 4'h0, 8'h03, 8'h00, 4'd6},
        {OP_TK, 4'h0, 8'h03, 8'h00, 4'd6},
        {OP_FL, 4'h0, 8'h00, 8'h01, 4'd6},   // R6 toggled low
        {OP_RD, 4'h7, 8'h00, 8'h00, 4'd2}    // R2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       t1_autoreload = 1'b0, t1_pin_toggle = 1'b0;
    logic [7:0] rdata;
    logic       t1_flag, t2_flag, wave_out;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_interval_timer u_dual_interval_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .t1_autoreload (t1_autoreload),
        .t1_pin_toggle (t1_pin_toggle),
        .rdata         (rdata),
        .t1_flag       (t1_flag),
        .t2_flag       (t2_flag),
        .wave_out      (wave_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic t,
                        input logic [3:0] a, input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        wr_en = w; rd_en = r; tick = t; addr = a; wdata = d;
        #1 q = rdata;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    endtask

    task automatic peek(output logic [7:0] f);
        @(negedge clk);
        #1 f = {5'b0, wave_out, t2_flag, t1_flag};
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] q;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        peek(q);                              chk("R1 flags", q, 8'h00);
        step(0, 1, 0, 4'h4, 0, q);            chk("R1 cnt lo", q, 8'hFF);
        step(0, 1, 0, 4'h5, 0, q);            chk("R1 cnt hi", q, 8'hFF);
        step(0, 1, 0, 4'h6, 0, q);            chk("R1 latch lo", q, 8'h00);
        step(0, 1, 0, 4'h9, 0, q);            chk("R1 t2 cnt hi", q, 8'hFF);
        for (int k = 0; k < 3; k++) step(0, 0, 1, 4'h0, 0, q);
        step(0, 1, 0, 4'h4, 0, q);            chk("R1 idle cnt", q, 8'hFF);
        step(0, 1, 0, 4'h8, 0, q);            chk("R1 idle t2 cnt", q, 8'hFF);

        // vector table
        for (int v = 0; v < N_VEC; v++) begin
            logic [1:0] op;
            logic [3:0] a;
            logic [7:0] d, e;
            string      rq;
            {op, a, d, e} = VEC[v][25:4];
            rq = $sformatf("R%0d vec %0d", VEC[v][3:0], v);
            case (op)
                OP_WR: step(1, 0, 0, a, d, q);
                OP_RD: begin step(0, 1, 0, a, 0, q); chk(rq, q, e); end
                OP_TK: begin
                    t1_autoreload = d[0];
                    t1_pin_toggle = d[1];
                    step(0, 0, 1, 4'h0, 0, q);
                end
                default: begin peek(q); chk(rq, q, e); end
            endcase
        end

        // R2: high latch write leaves counter (at 4) alone
        t1_autoreload = 1'b0; t1_pin_toggle = 1'b0;
        step(1, 0, 0, 4'h7, 8'h12, q);
        step(0, 1, 0, 4'h7, 0, q);            chk("R2 latch hi", q, 8'h12);
        step(0, 1, 0, 4'h5, 0, q);            chk("R2 cnt hi kept", q, 8'h00);
        step(0, 1, 0, 4'h4, 0, q);            chk("R2 cnt lo kept", q, 8'h04);

        // R3: start with a tick in the same cycle
        step(1, 0, 0, 4'h4, 8'h05, q);
        step(1, 0, 1, 4'h5, 8'h00, q);
        step(0, 1, 0, 4'h4, 0, q);            chk("R3 tick ignored", q, 8'h05);
        step(0, 1, 0, 4'h7, 0, q);            chk("R3 latch hi", q, 8'h00);

        // R8: timeout and clearing read in one cycle
        for (int k = 0; k < 5; k++) step(0, 0, 1, 4'h0, 0, q);
        step(0, 1, 1, 4'h4, 0, q);            chk("R8 read value", q, 8'h00);
        peek(q);                              chk("R8 set wins", q, 8'h01);
        step(0, 1, 0, 4'h4, 0, q);
        peek(q);                              chk("R7 later clear", q, 8'h00);

        // R10: unmapped offset and idle bus
        step(0, 1, 0, 4'hC, 0, q);            chk("R10 unmapped", q, 8'h00);
        @(negedge clk); addr = 4'h5; #1 q = rdata;
        chk("R10 no read", q, 8'h00);

        // R1: mid-run reset
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step(0, 1, 0, 4'h5, 0, q);            chk("R1 re-reset cnt hi", q, 8'hFF);
        step(0, 1, 0, 4'h7, 0, q);            chk("R1 re-reset latch hi", q, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule